// File: doc/BRIEF.md
# SPI Channel Transfer Sequencer

This block is a single channel of a multichannel SPI master. It keeps a transmit holding word, a receive word and three status flags (receive full, transmit empty, end of transfer). Each time something could make a transfer possible, it decides whether a word may be shifted. The triggers are a write of transmit data, a read of receive data and the channel being switched on. The decision depends on the channel enable, the transfer mode and the flags. When a shift is allowed it runs an MSB-first master shift of the programmed length on SCLK, MOSI and MISO, with chip select held low for the whole word.

The transfer mode chooses full duplex, receive-only or transmit-only operation. That choice decides which flags hold a transfer back, which flags are set at completion, which one-cycle interrupt pulses are raised and which DMA request levels are driven. A slave-mode input with a force override can suppress the serial shift. In that case a transfer completes at once with no SCLK activity. A trigger that arrives while a shift is running is remembered and evaluated again when the shift finishes.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset tx_empty_o is 1, rx_full_o, eot_o, sclk_o, irq_tx_o, irq_rx_o, dma_tx_o and dma_rx_o are 0, and cs_no is 1.
- R2: A transfer is attempted only while chan_en_i is 1. A 0-to-1 change of chan_en_i is itself an attempt. Writes made while the channel is off start nothing and raise no interrupt.
- R3: An attempt is held back when rx_full_o is 1, mode_i is not 2 and rx_ovr_i is 0. It is also held back when tx_empty_o is 1 and mode_i is not 1. A held-back attempt leaves cs_no high.
- R4: A shift of length wlen_i+1 drives cs_no low for 2*(wlen_i+1) clock cycles. SCLK runs at half the clock rate and idles low. MOSI sends the word MSB first and changes after falling SCLK. MISO is captured when SCLK rises, and rx_data_o receives the captured bits in its low wlen_i+1 bits with zeros above.
- R5: At completion tx_empty_o and eot_o are set. rx_full_o is set unless mode_i is 2. The transmit holding word becomes zero, so a later receive-only shift sends all zeros.
- R6: mode_i encodes 0 duplex, 1 receive-only, 2 transmit-only. Code 3 behaves as duplex.
- R7: tx_wr_i loads tx_data_i and clears tx_empty_o. rx_rd_i clears rx_full_o. Both are attempts.
- R8: With slave_mode_i=1 and force_shift_i=0, an allowed attempt completes in one cycle. SCLK does not toggle, cs_no stays high and rx_data_o is unchanged.
- R9: On every evaluated attempt and every completion, the following flags are judged on their new values. irq_tx_o pulses for one cycle if tx_empty_o is 1 and mode_i is not 1. irq_rx_o pulses if rx_full_o is 1, mode_i is not 2 and rx_ovr_i is 0.
- R10: dma_tx_o is high while chan_en_i, tx_dma_en_i and tx_empty_o are 1 and mode_i is not 1. dma_rx_o is high while chan_en_i, rx_dma_en_i and rx_full_o are 1 and mode_i is not 2.
- R11: An attempt during a shift is kept pending and evaluated in the cycle after completion. A word written during a shift keeps tx_empty_o at 0 through the completion and is shifted next.
- R12: eot_o is cleared in the cycle a shift starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable |
| mode_i | input | 2 | Transfer mode |
| wlen_i | input | 5 | Word length minus one |
| rx_ovr_i | input | 1 | Receive full does not hold back transfers or raise receive interrupts |
| slave_mode_i | input | 1 | Module is not the bus master |
| force_shift_i | input | 1 | Shift even in slave mode |
| tx_dma_en_i | input | 1 | Transmit DMA request enable |
| rx_dma_en_i | input | 1 | Receive DMA request enable |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | 32 | Transmit data |
| rx_rd_i | input | 1 | Receive data read strobe |
| rx_data_o | output | 32 | Receive data word |
| rx_full_o | output | 1 | Receive full flag |
| tx_empty_o | output | 1 | Transmit empty flag |
| eot_o | output | 1 | End of transfer flag |
| irq_tx_o | output | 1 | Transmit empty interrupt pulse |
| irq_rx_o | output | 1 | Receive full interrupt pulse |
| dma_tx_o | output | 1 | Transmit DMA request level |
| dma_rx_o | output | 1 | Receive DMA request level |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The assertions check, on every cycle, the invariants that tie the flags to their causes. Transmit empty falls only after a write. Receive full rises only together with end of transfer and never in transmit-only mode. SCLK idles low while deselected. A shift starts only on an enabled channel and always clears end of transfer. Interrupt pulses and DMA requests never appear without their flag. Only the bench scenarios can show the ordering behaviours: which trigger is held back by which flag in each mode, bit order and cycle count of the shift, a pending write following a running shift, the zeroed holding word in receive-only mode and the shift-less completion in slave mode.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    MODE_DUPLEX  = 2'd0,
    MODE_RX_ONLY = 2'd1,
    MODE_TX_ONLY = 2'd2,
    MODE_RSVD    = 2'd3
  } xfer_mode_e;

  // transmit side participates unless receive-only
  function automatic logic tx_side(xfer_mode_e m);
    return m != MODE_RX_ONLY;
  endfunction

  // receive side participates unless transmit-only
  function automatic logic rx_side(xfer_mode_e m);
    return m != MODE_TX_ONLY;
  endfunction
endpackage

// File: rtl/spi_seq_gate.sv
module spi_seq_gate
  import spi_seq_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       rx_ovr_i,
  input  logic       rx_full_i,
  input  logic       tx_empty_i,
  output logic       tx_hold_o,
  output logic       rx_hold_o
);
  xfer_mode_e mode;
  assign mode      = xfer_mode_e'(mode_i);
  assign tx_hold_o = tx_empty_i & tx_side(mode);
  assign rx_hold_o = rx_full_i & rx_side(mode) & ~rx_ovr_i;
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
  parameter int DW = 32,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] word_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          cs_no
);
  logic          busy_q, sclk_q;
  logic [LW-1:0] cnt_q, len_q;
  logic [DW-1:0] tx_sh_q, rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      sclk_q  <= 1'b0;
      cnt_q   <= len_i;
      len_q   <= len_i;
      tx_sh_q <= word_i;
      rx_sh_q <= '0;
    end else if (busy_q) begin
      if (!sclk_q) begin
        sclk_q  <= 1'b1;
        rx_sh_q <= {rx_sh_q[DW-2:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q   <= cnt_q - 1'b1;
          tx_sh_q <= {tx_sh_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q & sclk_q & (cnt_q == '0);
  assign rx_word_o = rx_sh_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = busy_q & tx_sh_q[len_q];
  assign cs_no     = ~busy_q;
endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
  import spi_seq_pkg::*;
#(
  parameter int DW = 32,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chan_en_i,
  input  logic [1:0]    mode_i,
  input  logic [LW-1:0] wlen_i,
  input  logic          rx_ovr_i,
  input  logic          slave_mode_i,
  input  logic          force_shift_i,
  input  logic          tx_dma_en_i,
  input  logic          rx_dma_en_i,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          rx_rd_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  output logic          tx_empty_o,
  output logic          eot_o,
  output logic          irq_tx_o,
  output logic          irq_rx_o,
  output logic          dma_tx_o,
  output logic          dma_rx_o,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          cs_no
);
  logic          en_q, pend_q, tx_new_q;
  logic          rx_full_q, tx_empty_q, eot_q, irq_tx_q, irq_rx_q;
  logic [DW-1:0] tx_q, rx_q;

  logic          busy, done;
  logic [DW-1:0] rx_word, word_n;
  logic          ev, attempt, blocked, shift_ok, start, quick, complete, irq_ev;
  logic          rxf_n, txe_n, rx_full_d, tx_empty_d, eot_d;
  logic          ev_tx_hold, ev_rx_hold, post_tx_hold, post_rx_hold;
  logic          cur_tx_req, cur_rx_req;

  assign ev    = (chan_en_i & ~en_q) | tx_wr_i | rx_rd_i;
  assign rxf_n = rx_full_q & ~rx_rd_i;
  assign txe_n = tx_empty_q & ~tx_wr_i;

  spi_seq_gate u_gate_eval (
    .mode_i(mode_i), .rx_ovr_i(rx_ovr_i), .rx_full_i(rxf_n), .tx_empty_i(txe_n),
    .tx_hold_o(ev_tx_hold), .rx_hold_o(ev_rx_hold)
  );

  assign attempt  = chan_en_i & ~busy & (ev | pend_q);
  assign blocked  = ev_tx_hold | ev_rx_hold;
  assign shift_ok = ~slave_mode_i | force_shift_i;
  assign start    = attempt & ~blocked & shift_ok;
  assign quick    = attempt & ~blocked & ~shift_ok;
  assign complete = done | quick;
  assign irq_ev   = complete | (attempt & blocked);
  assign word_n   = tx_wr_i ? tx_data_i : tx_q;

  always_comb begin
    rx_full_d = rxf_n;
    if (complete && rx_side(xfer_mode_e'(mode_i))) rx_full_d = 1'b1;
    if (done)       tx_empty_d = ~(tx_new_q | tx_wr_i);
    else if (quick) tx_empty_d = 1'b1;
    else            tx_empty_d = txe_n;
    if (complete)   eot_d = 1'b1;
    else if (start) eot_d = 1'b0;
    else            eot_d = eot_q;
  end

  // interrupt conditions judged on the flags being written this cycle
  spi_seq_gate u_gate_post (
    .mode_i(mode_i), .rx_ovr_i(rx_ovr_i), .rx_full_i(rx_full_d), .tx_empty_i(tx_empty_d),
    .tx_hold_o(post_tx_hold), .rx_hold_o(post_rx_hold)
  );

  // DMA levels ignore the overrun setting
  spi_seq_gate u_gate_dma (
    .mode_i(mode_i), .rx_ovr_i(1'b0), .rx_full_i(rx_full_q), .tx_empty_i(tx_empty_q),
    .tx_hold_o(cur_tx_req), .rx_hold_o(cur_rx_req)
  );

  spi_seq_shifter #(.DW(DW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .len_i(wlen_i), .word_i(word_n),
    .miso_i(miso_i), .busy_o(busy), .done_o(done), .rx_word_o(rx_word),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_no(cs_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
      tx_new_q   <= 1'b0;
      rx_full_q  <= 1'b0;
      tx_empty_q <= 1'b1;
      eot_q      <= 1'b0;
      irq_tx_q   <= 1'b0;
      irq_rx_q   <= 1'b0;
      tx_q       <= '0;
      rx_q       <= '0;
    end else begin
      en_q       <= chan_en_i;
      rx_full_q  <= rx_full_d;
      tx_empty_q <= tx_empty_d;
      eot_q      <= eot_d;
      irq_tx_q   <= irq_ev & post_tx_hold;
      irq_rx_q   <= irq_ev & post_rx_hold;

      if (!chan_en_i)      pend_q <= 1'b0;
      else if (busy && ev) pend_q <= 1'b1;
      else if (attempt)    pend_q <= 1'b0;

      if (start)                tx_new_q <= 1'b0;
      else if (busy && tx_wr_i) tx_new_q <= 1'b1;

      if (start || quick) tx_q <= '0;
      else if (tx_wr_i)   tx_q <= tx_data_i;

      if (done) rx_q <= rx_word;
    end
  end

  assign rx_data_o  = rx_q;
  assign rx_full_o  = rx_full_q;
  assign tx_empty_o = tx_empty_q;
  assign eot_o      = eot_q;
  assign irq_tx_o   = irq_tx_q;
  assign irq_rx_o   = irq_rx_q;
  assign dma_tx_o   = chan_en_i & tx_dma_en_i & cur_tx_req;
  assign dma_rx_o   = chan_en_i & rx_dma_en_i & cur_rx_req;
endmodule

// File: rtl/spi_chan_seq_chk.sv
module spi_chan_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chan_en_i,
  input logic [1:0] mode_i,
  input logic       tx_wr_i,
  input logic       rx_full_o,
  input logic       tx_empty_o,
  input logic       eot_o,
  input logic       irq_tx_o,
  input logic       irq_rx_o,
  input logic       dma_tx_o,
  input logic       dma_rx_o,
  input logic       sclk_o,
  input logic       cs_no
);
  // R7
  tx_empty_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_empty_o) |-> $past(tx_wr_i));
  // R5
  rx_full_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> (eot_o && $past(mode_i) != 2'd2));
  // R4
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R2
  start_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(chan_en_i));
  // R12
  eot_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !eot_o);
  // R9
  irq_tx_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tx_o |-> (tx_empty_o && $past(mode_i) != 2'd1));
  // R9
  irq_rx_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_o |-> rx_full_o);
  // R10
  dma_rx_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rx_o |-> (rx_full_o && chan_en_i));
  // R10
  dma_tx_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_tx_o |-> (tx_empty_o && mode_i != 2'd1));
endmodule

bind spi_chan_seq spi_chan_seq_chk u_chk (.*);

// File: tb/spi_chan_seq_test.sv
`timescale 1ns/1ps
module spi_chan_seq_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        chan_en_i = 0, rx_ovr_i = 0, slave_mode_i = 0, force_shift_i = 0;
  logic        tx_dma_en_i = 0, rx_dma_en_i = 0, tx_wr_i = 0, rx_rd_i = 0, miso_i = 0;
  logic [1:0]  mode_i = 2'd0;
  logic [4:0]  wlen_i = 5'd7;
  logic [31:0] tx_data_i = '0;
  logic [31:0] rx_data_o;
  logic        rx_full_o, tx_empty_o, eot_o, irq_tx_o, irq_rx_o;
  logic        dma_tx_o, dma_rx_o, sclk_o, mosi_o, cs_no;

  int nvec = 0, nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_chan_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .chan_en_i(chan_en_i), .mode_i(mode_i), .wlen_i(wlen_i),
    .rx_ovr_i(rx_ovr_i), .slave_mode_i(slave_mode_i), .force_shift_i(force_shift_i),
    .tx_dma_en_i(tx_dma_en_i), .rx_dma_en_i(rx_dma_en_i), .tx_wr_i(tx_wr_i),
    .tx_data_i(tx_data_i), .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o), .rx_full_o(rx_full_o),
    .tx_empty_o(tx_empty_o), .eot_o(eot_o), .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o),
    .dma_tx_o(dma_tx_o), .dma_rx_o(dma_rx_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .cs_no(cs_no)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard queues and slave model queues
  logic [31:0] exp_rx[$], exp_mosi[$], slv_q[$];
  int          exp_len[$], slv_len_q[$];

  task automatic expect_xfer(int len, logic [31:0] slv, logic [31:0] mosi);
    logic [31:0] mask;
    mask = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
    slv_q.push_back(slv);
    slv_len_q.push_back(len);
    exp_rx.push_back(slv & mask);
    exp_mosi.push_back(mosi & mask);
    exp_len.push_back(len);
  endtask

  // slave: presents MSB first, advances after falling SCLK, records MOSI on rising SCLK
  logic [31:0] slv_cur = '0, mcap = '0;
  int          slv_idx = 0;
  always @(negedge cs_no) begin
    slv_cur = (slv_q.size() > 0) ? slv_q.pop_front() : 32'h0;
    slv_idx = (slv_len_q.size() > 0) ? slv_len_q.pop_front() - 1 : 0;
    miso_i  = slv_cur[slv_idx];
    mcap    = '0;
  end
  always @(negedge sclk_o) begin
    if (cs_no === 1'b0) begin
      slv_idx--;
      if (slv_idx >= 0) miso_i = slv_cur[slv_idx];
    end
  end
  always @(posedge sclk_o) begin
    if (cs_no === 1'b0) mcap = {mcap[30:0], mosi_o};
  end

  // monitor: compares each finished shift against the queue
  bit prev_cs = 1'b1;
  int low_cnt = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_no === 1'b0) low_cnt++;
      else if (!prev_cs) begin
        if (exp_rx.size() == 0) chk("R4 unexpected shift", 32'd1, 32'd0);
        else begin
          int l;
          l = exp_len.pop_front();
          chk("R4 rx word", rx_data_o, exp_rx.pop_front());
          chk("R4 mosi word", mcap, exp_mosi.pop_front());
          chk("R4 select cycles", low_cnt, 2 * l);
        end
        low_cnt = 0;
      end
    end
    prev_cs = cs_no;
  end

  task automatic pulse_wr(logic [31:0] d);
    @(negedge clk); tx_wr_i = 1'b1; tx_data_i = d;
    @(negedge clk); tx_wr_i = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd_i = 1'b1;
    @(negedge clk); rx_rd_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end while (cs_no !== 1'b1 && n < 300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_empty", tx_empty_o, 1);
    chk("R1 rx_full", rx_full_o, 0);
    chk("R1 eot", eot_o, 0);
    chk("R1 cs", cs_no, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 irq", {irq_tx_o, irq_rx_o, dma_tx_o, dma_rx_o}, 0);

    // R2 write while disabled: no shift, no interrupt
    pulse_wr(32'hA5);
    chk("R7 tx_empty cleared", tx_empty_o, 0);
    chk("R2 no irq while off", irq_tx_o, 0);
    repeat (3) @(negedge clk);
    chk("R2 no shift while off", cs_no, 1);
    // R2 enabling is an attempt
    expect_xfer(8, 32'h3C, 32'hA5);
    chan_en_i = 1'b1;
    @(negedge clk);
    chk("R2 enable starts shift", cs_no, 0);
    wait_done();
    chk("R5 rx_full set", rx_full_o, 1);
    chk("R5 eot set", eot_o, 1);
    chk("R5 tx_empty set", tx_empty_o, 1);
    chk("R9 irq_tx", irq_tx_o, 1);
    chk("R9 irq_rx", irq_rx_o, 1);

    // R3 receive full holds back a duplex write
    pulse_wr(32'h5A);
    chk("R3 held by rx_full", cs_no, 1);
    chk("R9 blocked irq_rx", irq_rx_o, 1);
    chk("R9 blocked irq_tx", irq_tx_o, 0);
    chk("R4 rx_data before read", rx_data_o, 32'h3C);
    expect_xfer(8, 32'hC3, 32'h5A);
    pulse_rd();
    chk("R7 rx_full cleared", rx_full_o, 0);
    chk("R7 read starts shift", cs_no, 0);
    chk("R12 eot cleared", eot_o, 0);
    wait_done();

    // R6 transmit-only, 16 bits
    mode_i = 2'd2; wlen_i = 5'd15;
    pulse_rd();
    chk("R3 held by tx_empty", cs_no, 1);
    chk("R9 tx-only irq_tx", irq_tx_o, 1);
    expect_xfer(16, 32'hBEEF, 32'h1234);
    pulse_wr(32'h1234);
    wait_done();
    chk("R5 tx-only rx_full stays clear", rx_full_o, 0);
    chk("R9 tx-only no irq_rx", irq_rx_o, 0);

    // R6 receive-only, 32 bits; zeroed holding word goes out
    mode_i = 2'd1; wlen_i = 5'd31; tx_dma_en_i = 1'b1; rx_dma_en_i = 1'b1;
    @(negedge clk);
    chk("R10 no tx dma in rx-only", dma_tx_o, 0);
    expect_xfer(32, 32'hDEADBEEF, 32'h0);
    pulse_rd();
    chk("R6 rx-only read starts", cs_no, 0);
    wait_done();
    chk("R9 rx-only irq_rx", irq_rx_o, 1);
    chk("R9 rx-only no irq_tx", irq_tx_o, 0);
    chk("R10 rx dma", dma_rx_o, 1);

    // R3 receive full holds back rx-only unless overrun allowed
    chan_en_i = 1'b0;
    @(negedge clk);
    chk("R10 rx dma off when disabled", dma_rx_o, 0);
    chan_en_i = 1'b1;
    @(negedge clk);
    chk("R3 rx-only held by rx_full", cs_no, 1);
    chk("R9 blocked rx-only irq_rx", irq_rx_o, 1);
    chan_en_i = 1'b0; rx_ovr_i = 1'b1;
    @(negedge clk);
    expect_xfer(32, 32'h0F0F1234, 32'h0);
    chan_en_i = 1'b1;
    @(negedge clk);
    chk("R3 overrun allows shift", cs_no, 0);
    wait_done();
    chk("R9 overrun suppresses irq_rx", irq_rx_o, 0);

    // R11 write during a shift stays pending
    mode_i = 2'd0; wlen_i = 5'd3; tx_dma_en_i = 1'b0; rx_dma_en_i = 1'b0;
    expect_xfer(4, 32'h9, 32'h6);
    pulse_wr(32'h6);
    expect_xfer(4, 32'h5, 32'hA);
    pulse_wr(32'hA);
    wait_done();
    chk("R11 tx_empty kept clear", tx_empty_o, 0);
    chk("R11 no irq_tx", irq_tx_o, 0);
    @(negedge clk);
    chk("R11 pending shift starts", cs_no, 0);
    wait_done();

    // R8 slave mode completes without shifting
    slave_mode_i = 1'b1;
    pulse_wr(32'h3);
    chk("R8 no select", cs_no, 1);
    chk("R8 tx_empty set", tx_empty_o, 1);
    chk("R8 eot set", eot_o, 1);
    chk("R8 rx_data unchanged", rx_data_o, 32'h5);
    chk("R8 irq_tx", irq_tx_o, 1);
    repeat (2) @(negedge clk);
    chk("R8 sclk idle", {sclk_o, cs_no}, 2'b01);
    force_shift_i = 1'b1;
    expect_xfer(4, 32'hE, 32'h7);
    pulse_wr(32'h7);
    chk("R8 force shifts", cs_no, 0);
    wait_done();

    // R6 code 3 acts as duplex
    slave_mode_i = 1'b0; force_shift_i = 1'b0; rx_ovr_i = 1'b0; mode_i = 2'd3;
    pulse_rd();
    chk("R6 code3 held by tx_empty", cs_no, 1);
    expect_xfer(4, 32'h2, 32'hD);
    pulse_wr(32'hD);
    wait_done();
    chk("R6 code3 rx_full", rx_full_o, 1);
    chk("R9 code3 irq_rx", irq_rx_o, 1);

    // R10 transmit DMA level
    tx_dma_en_i = 1'b1;
    @(negedge clk);
    chk("R10 tx dma", dma_tx_o, 1);
    chan_en_i = 1'b0;
    @(negedge clk);
    chk("R10 tx dma off", dma_tx_o, 0);

    repeat (4) @(negedge clk);
    chk("R4 all shifts seen", exp_rx.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule